// File: doc/BRIEF.md
# Next Fetch Address Predictor

This block sits in the fetch stage of a pipeline and, every cycle, turns the address of the instruction being fetched into the address to fetch next. It looks the fetch address up in a small direct-mapped table of branch targets. Each table entry also holds a 2-bit saturating counter that gives the predicted direction. When the entry hits and the branch is predicted taken, the cached target becomes the next fetch address. In every other case the next fetch address is the fetch address plus 4.

A two-bit policy input selects between the dynamic counter-based direction and three fixed policies: never taken, always taken on a hit, and taken only for backward targets.

When a branch resolves, the pipeline presents its address, its real outcome, its real target and the next address that was predicted for it. In that same cycle the block reports whether the prediction was wrong. At the next clock edge it allocates or refreshes the entry and trains the counter.

Top module: `nxt_fetch_pred`

## Requirements
- R1: A lookup hits when the entry selected by fetch address bits [5:2] is valid and its stored tag equals fetch address bits [31:6]. `lk_hit_o` shows this raw hit in every policy.
- R2: `lk_next_o` is the cached target when `lk_taken_o` is 1, and `lk_pc_i`+4 otherwise. A miss is never predicted taken.
- R3: With policy 2'b01 (never taken), `lk_taken_o` is 0 and `lk_next_o` is `lk_pc_i`+4 whatever the table holds.
- R4: With policy 2'b10 (always taken), every hit is predicted taken to the cached target.
- R5: With policy 2'b11 (backward only), a hit is predicted taken only when the cached target is lower than `lk_pc_i`, compared unsigned.
- R6: With policy 2'b00 (dynamic), a hit is predicted taken when its counter is 2'b10 or 2'b11. Counters reset to 2'b01. A newly allocated entry starts at 2'b10, which is the reset value stepped once for the taken outcome.
- R7: A resolved branch whose tag matches steps its counter up when taken (saturating at 2'b11) and down when not taken (saturating at 2'b00). A not-taken branch that misses changes nothing.
- R8: A resolved taken branch writes its tag and target into the entry at its index. If another branch holds that entry, the other branch is replaced.
- R9: `up_mispred_o` is 1 in the cycle `up_vld_i` is 1 exactly when `up_pred_i` differs from the real next address. The real next address is `up_tgt_i` if taken and `up_pc_i`+4 otherwise. `up_mispred_o` is 0 when `up_vld_i` is 0.
- R10: A lookup in the same cycle as an update to the same entry returns the entry's contents from before the update. The new contents are visible from the next cycle.
- R11: Reset invalidates every entry, so no lookup hits until a taken branch has been written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode_i | input | 2 | Direction policy: 00 dynamic, 01 never, 10 always, 11 backward |
| lk_pc_i | input | 32 | Address of the instruction being fetched |
| lk_hit_o | output | 1 | Table hit for `lk_pc_i` |
| lk_taken_o | output | 1 | Predicted taken |
| lk_next_o | output | 32 | Predicted next fetch address |
| up_vld_i | input | 1 | A branch resolved this cycle |
| up_pc_i | input | 32 | Address of the resolved branch |
| up_taken_i | input | 1 | Real outcome of the resolved branch |
| up_tgt_i | input | 32 | Real target of the resolved branch |
| up_pred_i | input | 32 | Next address that was predicted for that branch |
| up_mispred_o | output | 1 | The prediction for the resolved branch was wrong |

## Verification
A corrupted counter appears at the ports as a wrong `lk_taken_o` and `lk_next_o` in dynamic mode. It shows on the first lookup of that entry after the training update, one cycle later, so the bench walks a counter down to its floor and up to its ceiling and looks up the entry after every step.

A wrong tag or valid bit shows at once as a wrong `lk_hit_o`. The bench covers three cases of this: an evicted alias, a not-taken miss that must not allocate, and an entry cleared by reset. A stale target shows as a wrong `lk_next_o` under the always-taken policy on the cycle after the overwrite.

// File: rtl/nfp_pkg.sv
package nfp_pkg;

  typedef enum logic [1:0] {
    PM_DYN      = 2'b00,
    PM_NEVER    = 2'b01,
    PM_ALWAYS   = 2'b10,
    PM_BACKWARD = 2'b11
  } pmode_e;

  localparam logic [1:0] CTR_RST = 2'b01;

  function automatic logic [1:0] ctr_up(input logic [1:0] c);
    return (c == 2'b11) ? c : c + 2'b01;
  endfunction

  function automatic logic [1:0] ctr_dn(input logic [1:0] c);
    return (c == 2'b00) ? c : c - 2'b01;
  endfunction

endpackage

// File: rtl/nfp_rst_sync.sv
module nfp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb sync_d = {sync_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/nfp_table.sv
module nfp_table #(
  parameter int unsigned AW    = 32,
  parameter int unsigned IDX_W = 4,
  parameter int unsigned OFS   = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [IDX_W-1:0]          a_idx,
  output logic                      a_vld,
  output logic [AW-IDX_W-OFS-1:0]   a_tag,
  output logic [AW-1:0]             a_tgt,
  output logic [1:0]                a_ctr,
  input  logic [IDX_W-1:0]          b_idx,
  output logic                      b_vld,
  output logic [AW-IDX_W-OFS-1:0]   b_tag,
  output logic [AW-1:0]             b_tgt,
  output logic [1:0]                b_ctr,
  input  logic                      wr_en,
  input  logic [IDX_W-1:0]          wr_idx,
  input  logic [AW-IDX_W-OFS-1:0]   wr_tag,
  input  logic [AW-1:0]             wr_tgt,
  input  logic [1:0]                wr_ctr
);
  import nfp_pkg::*;

  localparam int unsigned ENTRIES = 1 << IDX_W;
  localparam int unsigned TAG_W   = AW - IDX_W - OFS;

  logic [ENTRIES-1:0] vld_q, vld_d;
  logic [1:0]         ctr_q [ENTRIES];
  logic [1:0]         ctr_d [ENTRIES];
  logic [TAG_W-1:0]   tag_q [ENTRIES];
  logic [AW-1:0]      tgt_q [ENTRIES];
  logic [ENTRIES-1:0] we;

  genvar e;
  generate
    for (e = 0; e < ENTRIES; e++) begin : g_we
      assign we[e] = wr_en && (wr_idx == IDX_W'(e));
    end
  endgenerate

  always_comb begin
    vld_d = vld_q;
    for (int i = 0; i < ENTRIES; i++) begin
      ctr_d[i] = ctr_q[i];
      if (we[i]) begin
        vld_d[i] = 1'b1;
        ctr_d[i] = wr_ctr;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      for (int i = 0; i < ENTRIES; i++) ctr_q[i] <= CTR_RST;
    end else begin
      vld_q <= vld_d;
      for (int i = 0; i < ENTRIES; i++) ctr_q[i] <= ctr_d[i];
    end
  end

  // payload storage needs no reset: the valid bit qualifies it
  always_ff @(posedge clk) begin
    for (int i = 0; i < ENTRIES; i++) begin
      if (we[i]) begin
        tag_q[i] <= wr_tag;
        tgt_q[i] <= wr_tgt;
      end
    end
  end

  // read ports see register contents, i.e. the state before this cycle's write
  assign a_vld = vld_q[a_idx];
  assign a_tag = tag_q[a_idx];
  assign a_tgt = tgt_q[a_idx];
  assign a_ctr = ctr_q[a_idx];
  assign b_vld = vld_q[b_idx];
  assign b_tag = tag_q[b_idx];
  assign b_tgt = tgt_q[b_idx];
  assign b_ctr = ctr_q[b_idx];
endmodule

// File: rtl/nfp_dir.sv
module nfp_dir #(
  parameter int unsigned AW   = 32,
  parameter int unsigned ILEN = 4
) (
  input  nfp_pkg::pmode_e mode,
  input  logic            hit,
  input  logic [1:0]      ctr,
  input  logic [AW-1:0]   tgt,
  input  logic [AW-1:0]   pc,
  output logic            taken,
  output logic [AW-1:0]   next_pc
);
  import nfp_pkg::*;

  logic want;

  always_comb begin
    unique case (mode)
      PM_DYN:      want = ctr[1];
      PM_NEVER:    want = 1'b0;
      PM_ALWAYS:   want = 1'b1;
      PM_BACKWARD: want = (tgt < pc);
      default:     want = 1'b0;
    endcase
    taken   = hit && want;
    next_pc = taken ? tgt : pc + AW'(ILEN);
  end
endmodule

// File: rtl/nfp_train.sv
module nfp_train #(
  parameter int unsigned AW    = 32,
  parameter int unsigned IDX_W = 4,
  parameter int unsigned OFS   = 2,
  parameter int unsigned ILEN  = 4
) (
  input  logic                    up_vld,
  input  logic [AW-1:0]           up_pc,
  input  logic                    up_taken,
  input  logic [AW-1:0]           up_tgt,
  input  logic [AW-1:0]           up_pred,
  input  logic                    rd_vld,
  input  logic [AW-IDX_W-OFS-1:0] rd_tag,
  input  logic [AW-1:0]           rd_tgt,
  input  logic [1:0]              rd_ctr,
  output logic [IDX_W-1:0]        idx,
  output logic                    wr_en,
  output logic [AW-IDX_W-OFS-1:0] wr_tag,
  output logic [AW-1:0]           wr_tgt,
  output logic [1:0]              wr_ctr,
  output logic                    mispred
);
  import nfp_pkg::*;

  logic          tag_hit;
  logic [AW-1:0] real_next;

  always_comb begin
    idx     = up_pc[OFS +: IDX_W];
    wr_tag  = up_pc[AW-1 : OFS+IDX_W];
    tag_hit = rd_vld && (rd_tag == wr_tag);
    wr_en   = up_vld && (up_taken || tag_hit);
    wr_tgt  = up_taken ? up_tgt : rd_tgt;
    if (tag_hit) wr_ctr = up_taken ? ctr_up(rd_ctr) : ctr_dn(rd_ctr);
    else         wr_ctr = ctr_up(CTR_RST);
    real_next = up_taken ? up_tgt : up_pc + AW'(ILEN);
    mispred   = up_vld && (up_pred != real_next);
  end
endmodule

// File: rtl/nxt_fetch_pred.sv
module nxt_fetch_pred #(
  parameter int unsigned AW    = 32,
  parameter int unsigned IDX_W = 4,
  parameter int unsigned ILEN  = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode_i,
  input  logic [AW-1:0] lk_pc_i,
  output logic          lk_hit_o,
  output logic          lk_taken_o,
  output logic [AW-1:0] lk_next_o,
  input  logic          up_vld_i,
  input  logic [AW-1:0] up_pc_i,
  input  logic          up_taken_i,
  input  logic [AW-1:0] up_tgt_i,
  input  logic [AW-1:0] up_pred_i,
  output logic          up_mispred_o
);
  import nfp_pkg::*;

  localparam int unsigned OFS   = $clog2(ILEN);
  localparam int unsigned TAG_W = AW - IDX_W - OFS;

  logic             rst_q_n;
  logic             a_vld, b_vld;
  logic [TAG_W-1:0] a_tag, b_tag, wr_tag;
  logic [AW-1:0]    a_tgt, b_tgt, wr_tgt;
  logic [1:0]       a_ctr, b_ctr, wr_ctr;
  logic [IDX_W-1:0] up_idx;
  logic             wr_en;
  pmode_e           mode;

  assign mode     = pmode_e'(mode_i);
  assign lk_hit_o = a_vld && (a_tag == lk_pc_i[AW-1 : OFS+IDX_W]);

  nfp_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_q_n)
  );

  nfp_table #(.AW(AW), .IDX_W(IDX_W), .OFS(OFS)) u_tab (
    .clk    (clk),
    .rst_n  (rst_q_n),
    .a_idx  (lk_pc_i[OFS +: IDX_W]),
    .a_vld  (a_vld),
    .a_tag  (a_tag),
    .a_tgt  (a_tgt),
    .a_ctr  (a_ctr),
    .b_idx  (up_idx),
    .b_vld  (b_vld),
    .b_tag  (b_tag),
    .b_tgt  (b_tgt),
    .b_ctr  (b_ctr),
    .wr_en  (wr_en),
    .wr_idx (up_idx),
    .wr_tag (wr_tag),
    .wr_tgt (wr_tgt),
    .wr_ctr (wr_ctr)
  );

  nfp_dir #(.AW(AW), .ILEN(ILEN)) u_dir (
    .mode    (mode),
    .hit     (lk_hit_o),
    .ctr     (a_ctr),
    .tgt     (a_tgt),
    .pc      (lk_pc_i),
    .taken   (lk_taken_o),
    .next_pc (lk_next_o)
  );

  nfp_train #(.AW(AW), .IDX_W(IDX_W), .OFS(OFS), .ILEN(ILEN)) u_trn (
    .up_vld   (up_vld_i),
    .up_pc    (up_pc_i),
    .up_taken (up_taken_i),
    .up_tgt   (up_tgt_i),
    .up_pred  (up_pred_i),
    .rd_vld   (b_vld),
    .rd_tag   (b_tag),
    .rd_tgt   (b_tgt),
    .rd_ctr   (b_ctr),
    .idx      (up_idx),
    .wr_en    (wr_en),
    .wr_tag   (wr_tag),
    .wr_tgt   (wr_tgt),
    .wr_ctr   (wr_ctr),
    .mispred  (up_mispred_o)
  );
endmodule

// File: rtl/nfp_chk.sv
module nfp_chk #(
  parameter int unsigned AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    mode_i,
  input logic [AW-1:0] lk_pc_i,
  input logic          lk_hit_o,
  input logic          lk_taken_o,
  input logic [AW-1:0] lk_next_o,
  input logic          up_vld_i,
  input logic [AW-1:0] up_pc_i,
  input logic          up_taken_i,
  input logic          up_mispred_o
);
  a_r2_miss_seq: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit_o |-> (!lk_taken_o && lk_next_o == lk_pc_i + AW'(4)));

  a_r3_never_seq: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'b01) |-> (!lk_taken_o && lk_next_o == lk_pc_i + AW'(4)));

  a_r4_always_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'b10) |-> (lk_taken_o == lk_hit_o));

  a_r5_bwd_lower: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'b11 && lk_taken_o) |-> (lk_next_o < lk_pc_i));

  a_r8_alloc_visible: assert property (@(posedge clk) disable iff (!rst_n)
    (up_vld_i && up_taken_i) |=> (lk_pc_i != $past(up_pc_i) || lk_hit_o));

  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !up_vld_i |-> !up_mispred_o);
endmodule

bind nxt_fetch_pred nfp_chk #(.AW(AW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .mode_i       (mode_i),
  .lk_pc_i      (lk_pc_i),
  .lk_hit_o     (lk_hit_o),
  .lk_taken_o   (lk_taken_o),
  .lk_next_o    (lk_next_o),
  .up_vld_i     (up_vld_i),
  .up_pc_i      (up_pc_i),
  .up_taken_i   (up_taken_i),
  .up_mispred_o (up_mispred_o)
);

// File: tb/sim_nxt_fetch_pred.sv
module sim_nxt_fetch_pred;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode_i = 2'b00;
  logic [31:0] lk_pc_i = '0;
  logic        lk_hit_o, lk_taken_o, up_mispred_o;
  logic [31:0] lk_next_o;
  logic        up_vld_i = 1'b0, up_taken_i = 1'b0;
  logic [31:0] up_pc_i = '0, up_tgt_i = '0, up_pred_i = '0;

  always #2 clk = ~clk;  // 250 MHz

  nxt_fetch_pred u0 (.*);

  typedef struct {
    logic        hit;
    logic        tk;
    logic [31:0] nxt;
    logic        mis;
    string       rq;
  } item_t;

  item_t q[$];
  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit fin   = 0;

  localparam logic [31:0] P1 = 32'h0000_2018, T1 = 32'h0000_2000;
  localparam logic [31:0] P2 = 32'h0000_3024, T2 = 32'h0000_3100;
  localparam logic [31:0] P3 = 32'h0000_2058, T3 = 32'h0000_2100;
  localparam logic [31:0] T4 = 32'h0000_2200, P4 = 32'h0000_4000;

  task automatic cmp(input string rq, input string f, input logic [31:0] a, input logic [31:0] e);
    total++;
    if (a !== e) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", rq, f, a, e);
    end
  endtask

  // monitor: pops one expected item per cycle, away from the clock edge
  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      cmp(it.rq, "hit",     32'(lk_hit_o),     32'(it.hit));
      cmp(it.rq, "taken",   32'(lk_taken_o),   32'(it.tk));
      cmp(it.rq, "next",    lk_next_o,         it.nxt);
      cmp(it.rq, "mispred", 32'(up_mispred_o), 32'(it.mis));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !fin) begin
      total++; bad++;
      $display("FAIL watchdog all-reqs act=timeout exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // driver: one cycle of stimulus plus its expected result
  task automatic drive(input logic [1:0] m, input logic [31:0] lpc,
                       input logic uv, input logic [31:0] upc, input logic utk,
                       input logic [31:0] utgt, input logic [31:0] upred,
                       input logic eh, input logic et, input logic [31:0] en,
                       input logic em, input string rq);
    item_t it;
    @(posedge clk); #1;
    mode_i = m; lk_pc_i = lpc;
    up_vld_i = uv; up_pc_i = upc; up_taken_i = utk; up_tgt_i = utgt; up_pred_i = upred;
    it.hit = eh; it.tk = et; it.nxt = en; it.mis = em; it.rq = rq;
    q.push_back(it);
  endtask

  task automatic do_reset();
    @(negedge clk);
    up_vld_i = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
  endtask

  initial begin
    do_reset();
    // R11: empty after reset
    drive(2'b00, P1, 0, 0, 0, 0, 0, 0, 0, P1+4, 0, "R11 empty");
    drive(2'b10, P2, 0, 0, 0, 0, 0, 0, 0, P2+4, 0, "R11 empty always");
    // R9 mispredict on taken, R10 same-cycle lookup sees old
    drive(2'b00, P1, 1, P1, 1, T1, P1+4, 0, 0, P1+4, 1, "R10 R9 alloc");
    drive(2'b00, P1, 0, 0, 0, 0, 0, 1, 1, T1, 0, "R1 R6 new entry");
    drive(2'b01, P1, 0, 0, 0, 0, 0, 1, 0, P1+4, 0, "R3 never");
    drive(2'b10, P1, 0, 0, 0, 0, 0, 1, 1, T1, 0, "R4 always");
    drive(2'b11, P1, 0, 0, 0, 0, 0, 1, 1, T1, 0, "R5 backward");
    drive(2'b00, P1, 1, P2, 1, T2, T2, 1, 1, T1, 0, "R9 correct");
    drive(2'b11, P2, 0, 0, 0, 0, 0, 1, 0, P2+4, 0, "R5 forward");
    drive(2'b10, P2, 0, 0, 0, 0, 0, 1, 1, T2, 0, "R4 always fwd");
    drive(2'b00, P2, 0, 0, 0, 0, 0, 1, 1, T2, 0, "R2 R6 dyn");
    // R7 walk down to floor
    drive(2'b00, P1, 1, P1, 0, 0, T1, 1, 1, T1, 1, "R10 R9 nt");
    drive(2'b00, P1, 1, P1, 0, 0, P1+4, 1, 0, P1+4, 0, "R7 ctr01");
    drive(2'b00, P1, 1, P1, 1, T1, P1+4, 1, 0, P1+4, 1, "R7 ctr00");
    drive(2'b00, P1, 1, P1, 1, T1, P1+4, 1, 0, P1+4, 1, "R7 floor 01");
    drive(2'b00, P1, 0, 0, 0, 0, 0, 1, 1, T1, 0, "R7 back 10");
    // R7 walk up to ceiling
    drive(2'b00, P2, 1, P2, 1, T2, T2, 1, 1, T2, 0, "R7 up");
    drive(2'b00, P2, 1, P2, 1, T2, T2, 1, 1, T2, 0, "R7 ceil");
    drive(2'b00, P2, 1, P2, 0, 0, P2+4, 1, 1, T2, 0, "R7 ceil 11");
    drive(2'b00, P2, 1, P2, 0, 0, P2+4, 1, 1, T2, 0, "R7 ceil held 10");
    drive(2'b00, P2, 0, 0, 0, 0, 0, 1, 0, P2+4, 0, "R7 down 01");
    // R7 not-taken miss writes nothing
    drive(2'b10, P4, 1, P4, 0, 0, P4+4, 0, 0, P4+4, 0, "R7 nt miss");
    drive(2'b10, P4, 0, 0, 0, 0, 0, 0, 0, P4+4, 0, "R7 no alloc");
    // R8 alias replaces
    drive(2'b00, P3, 1, P3, 1, T3, P3+4, 0, 0, P3+4, 1, "R8 alias");
    drive(2'b00, P3, 0, 0, 0, 0, 0, 1, 1, T3, 0, "R8 R6 fresh");
    drive(2'b10, P1, 0, 0, 0, 0, 0, 0, 0, P1+4, 0, "R8 evicted");
    drive(2'b10, P3, 1, P3, 1, T4, T3, 1, 1, T3, 1, "R8 R10 retarget");
    drive(2'b10, P3, 0, 0, 0, 0, 0, 1, 1, T4, 0, "R8 new target");
    drive(2'b00, P3, 0, 0, 0, 0, 0, 1, 1, T4, 0, "R7 ctr11");
    @(negedge clk); #1;
    do_reset();
    drive(2'b10, P3, 0, 0, 0, 0, 0, 0, 0, P3+4, 0, "R11 cleared");
    drive(2'b10, P2, 0, 0, 0, 0, 0, 0, 0, P2+4, 0, "R11 cleared 2");
    @(negedge clk); #1;
    fin = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule